// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block decides when a small CPU leaves normal execution to service an exception, and then runs the entry sequence. It handles three classes of exception. A reset comes from a rising edge on the reset pin or from a watchdog overflow strobe. An external interrupt request carries a vector number. A trap request also carries a vector number. Reset is taken at once, in any state. Interrupts and traps are considered only at an instruction boundary, which the execution unit marks with a one-cycle strobe.

For an interrupt or a trap, the block latches the current PC, CCR and stack pointer. It then writes three words below the stack pointer, each write waiting for the memory's ready signal. Next it pulses the mask-update strobe, forms the vector address and gives the fetch unit a one-cycle start strobe. A reset entry performs only the mask update, the vector step and the jump, and it always uses vector 0. The block drives no request acknowledge for a source it does not take. Such a request stays asserted by its owner and is served at a later boundary.

Top module: `exc_entry_seq`

## Requirements
- R1: Priority is fixed: a reset event beats an interrupt, and an interrupt beats a trap. In any cycle at most one of `irq_ack_o` and `trap_ack_o` is high. A request that is not acknowledged stays pending and is taken at a later boundary.
- R2: A reset entry starts on a low-to-high change of `rst_pin_i`, or on any cycle with `wdt_ovf_i` high. It needs no instruction boundary. A pin held high does not start a second entry.
- R3: An interrupt is accepted only in a cycle where the sequencer is idle, `insn_done_i` is high and CCR bit 7 (the interrupt mask) is 0. In that cycle `irq_ack_o` is high.
- R4: An interrupt is not accepted at a boundary where `ccr_write_i` is high. It is also not accepted at the first boundary after a reset entry completes. In both cases it is taken at a later boundary.
- R5: A trap is accepted at any idle boundary where no interrupt is accepted, whatever the mask bit, `ccr_write_i` or the post-reset block. `trap_ack_o` is high in that cycle.
- R6: An interrupt or trap entry makes exactly three stack writes, in order: PC[31:16] at SP-2, PC[15:0] at SP-4, and {8'h00, CCR} at SP-6. SP, PC and CCR are the values sampled at the accepting boundary. A write is held, with address and data stable, until `stk_rdy_i` is high.
- R7: A reset entry makes no stack write and ends with vector address 0.
- R8: Every completed entry raises `mask_set_o` for exactly one cycle, two cycles before `fetch_start_o`.
- R9: `fetch_start_o` is a one-cycle pulse. While it is high, `vec_addr_o` equals the taken source's vector number times 4.
- R10: A reset event during an entry abandons it. No further stack write occurs, and the reset entry follows with its own single fetch strobe at address 0.
- R11: With `stk_rdy_i` always high, `fetch_start_o` rises 6 cycles after the accepting boundary for an interrupt or trap. For a reset it rises 3 cycles after the event cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin_i | input | 1 | Reset pin; a rising edge requests reset entry |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| irq_req_i | input | 1 | Interrupt request, held until acknowledged |
| irq_vec_i | input | 8 | Interrupt vector number |
| trap_req_i | input | 1 | Trap request, held until acknowledged |
| trap_vec_i | input | 8 | Trap vector number |
| insn_done_i | input | 1 | Instruction boundary strobe |
| ccr_write_i | input | 1 | Finished instruction wrote the CCR |
| pc_i | input | 32 | Current program counter |
| ccr_i | input | 8 | Current condition code register, bit 7 is the mask |
| sp_i | input | 32 | Current stack pointer |
| stk_rdy_i | input | 1 | Stack memory accepts the current write |
| irq_ack_o | output | 1 | Interrupt accepted this cycle |
| trap_ack_o | output | 1 | Trap accepted this cycle |
| stk_we_o | output | 1 | Stack write request |
| stk_addr_o | output | 32 | Stack write address |
| stk_data_o | output | 16 | Stack write data |
| mask_set_o | output | 1 | Set the interrupt mask bit now |
| vec_addr_o | output | 32 | Vector address for the new fetch |
| fetch_start_o | output | 1 | Start fetching at `vec_addr_o` |

## Verification
The bench goes after three kinds of case. The first is priority collisions: reset with a boundary, interrupt with trap, and a trap under a masked or suppressed interrupt. A design that got these wrong would acknowledge two sources at once or lose the request it skipped. The second is the two suppression windows, one after a CCR-writing instruction and one after reset entry. An interrupt accepted inside either window would start an entry that should not exist. The third is a reset landing in a stalled push or in the vector step. A design that failed to abandon the entry would emit extra stack writes or a second fetch strobe at the old vector. Random runs with random ready stalls check the pushed addresses and data against bench-computed values.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int ADDR_W_D    = 32;
    localparam int WORD_W_D    = 16;
    localparam int CCR_W_D     = 8;
    localparam int VEC_W_D     = 8;
    localparam int MASK_BIT_D  = 7;
    localparam int VEC_BYTES_D = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC_HI,
        ST_PUSH_PC_LO,
        ST_PUSH_CCR,
        ST_SET_MASK,
        ST_VECTOR,
        ST_JUMP
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_RST,
        SRC_IRQ,
        SRC_TRAP
    } exc_src_t;

    function automatic logic is_push(seq_state_t s);
        return (s == ST_PUSH_PC_HI) || (s == ST_PUSH_PC_LO) || (s == ST_PUSH_CCR);
    endfunction

endpackage

// File: rtl/exc_reset_detect.sv
module exc_reset_detect (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic wdt_i,
    output logic evt_o
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_i;
    end

    // rising edge of the pin or a watchdog pulse
    assign evt_o = (pin_i & ~pin_q) | wdt_i;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter (
    input  logic open_i,
    input  logic boundary_i,
    input  logic masked_i,
    input  logic ccr_wr_i,
    input  logic post_rst_i,
    input  logic irq_req_i,
    input  logic trap_req_i,
    output logic take_irq_o,
    output logic take_trap_o
);
    logic slot;
    logic irq_ok;

    assign slot        = open_i & boundary_i;
    assign irq_ok      = irq_req_i & ~masked_i & ~ccr_wr_i & ~post_rst_i;
    assign take_irq_o  = slot & irq_ok;
    assign take_trap_o = slot & trap_req_i & ~irq_ok;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_D,
    parameter int WORD_W    = WORD_W_D,
    parameter int CCR_W     = CCR_W_D,
    parameter int VEC_W     = VEC_W_D,
    parameter int MASK_BIT  = MASK_BIT_D,
    parameter int VEC_BYTES = VEC_BYTES_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_i,
    input  logic              wdt_ovf_i,
    input  logic              irq_req_i,
    input  logic [VEC_W-1:0]  irq_vec_i,
    input  logic              trap_req_i,
    input  logic [VEC_W-1:0]  trap_vec_i,
    input  logic              insn_done_i,
    input  logic              ccr_write_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [CCR_W-1:0]  ccr_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic              stk_rdy_i,
    output logic              irq_ack_o,
    output logic              trap_ack_o,
    output logic              stk_we_o,
    output logic [ADDR_W-1:0] stk_addr_o,
    output logic [WORD_W-1:0] stk_data_o,
    output logic              mask_set_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              fetch_start_o
);
    localparam int VEC_SH  = $clog2(VEC_BYTES);
    localparam int WORD_BY = WORD_W / 8;

    seq_state_t        state;
    exc_src_t          src;
    logic [ADDR_W-1:0] pc_r;
    logic [ADDR_W-1:0] sp_r;
    logic [CCR_W-1:0]  ccr_r;
    logic [VEC_W-1:0]  vec_r;
    logic [ADDR_W-1:0] va_r;
    logic              post_rst;
    logic              rst_evt;
    logic              take_irq;
    logic              take_trap;

    exc_reset_detect u_rdet (
        .clk   (clk),
        .rst   (rst),
        .pin_i (rst_pin_i),
        .wdt_i (wdt_ovf_i),
        .evt_o (rst_evt)
    );

    exc_arbiter u_arb (
        .open_i      ((state == ST_IDLE) && !rst_evt),
        .boundary_i  (insn_done_i),
        .masked_i    (ccr_i[MASK_BIT]),
        .ccr_wr_i    (ccr_write_i),
        .post_rst_i  (post_rst),
        .irq_req_i   (irq_req_i),
        .trap_req_i  (trap_req_i),
        .take_irq_o  (take_irq),
        .take_trap_o (take_trap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            src      <= SRC_RST;
            pc_r     <= '0;
            sp_r     <= '0;
            ccr_r    <= '0;
            vec_r    <= '0;
            va_r     <= '0;
            post_rst <= 1'b0;
        end else if (rst_evt) begin
            // reset overrides whatever entry is under way
            state <= ST_SET_MASK;
            src   <= SRC_RST;
            vec_r <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (insn_done_i) post_rst <= 1'b0;
                    if (take_irq || take_trap) begin
                        state <= ST_PUSH_PC_HI;
                        src   <= take_irq ? SRC_IRQ : SRC_TRAP;
                        vec_r <= take_irq ? irq_vec_i : trap_vec_i;
                        pc_r  <= pc_i;
                        sp_r  <= sp_i;
                        ccr_r <= ccr_i;
                    end
                end
                ST_PUSH_PC_HI: if (stk_rdy_i) begin
                    sp_r  <= sp_r - ADDR_W'(WORD_BY);
                    state <= ST_PUSH_PC_LO;
                end
                ST_PUSH_PC_LO: if (stk_rdy_i) begin
                    sp_r  <= sp_r - ADDR_W'(WORD_BY);
                    state <= ST_PUSH_CCR;
                end
                ST_PUSH_CCR: if (stk_rdy_i) begin
                    sp_r  <= sp_r - ADDR_W'(WORD_BY);
                    state <= ST_SET_MASK;
                end
                ST_SET_MASK: state <= ST_VECTOR;
                ST_VECTOR: begin
                    va_r  <= ADDR_W'(vec_r) << VEC_SH;
                    state <= ST_JUMP;
                end
                ST_JUMP: begin
                    if (src == SRC_RST) post_rst <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_PUSH_PC_HI: stk_data_o = pc_r[ADDR_W-1 -: WORD_W];
            ST_PUSH_PC_LO: stk_data_o = pc_r[WORD_W-1:0];
            ST_PUSH_CCR:   stk_data_o = WORD_W'(ccr_r);
            default:       stk_data_o = '0;
        endcase
    end

    assign stk_we_o      = is_push(state);
    assign stk_addr_o    = sp_r - ADDR_W'(WORD_BY);
    assign mask_set_o    = (state == ST_SET_MASK);
    assign fetch_start_o = (state == ST_JUMP);
    assign vec_addr_o    = va_r;
    assign irq_ack_o     = take_irq;
    assign trap_ack_o    = take_trap;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int ADDR_W   = 32,
    parameter int WORD_W   = 16,
    parameter int CCR_W    = 8,
    parameter int MASK_BIT = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_pin_i,
    input logic              wdt_ovf_i,
    input logic              insn_done_i,
    input logic              ccr_write_i,
    input logic [CCR_W-1:0]  ccr_i,
    input logic              stk_rdy_i,
    input logic              irq_ack_o,
    input logic              trap_ack_o,
    input logic              stk_we_o,
    input logic [ADDR_W-1:0] stk_addr_o,
    input logic [WORD_W-1:0] stk_data_o,
    input logic              mask_set_o,
    input logic              fetch_start_o
);
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq_ack_o && trap_ack_o)); // R1

    AST_IRQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        irq_ack_o |-> (insn_done_i && !ccr_i[MASK_BIT] && !ccr_write_i)); // R3

    AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stk_we_o && !stk_rdy_i && !wdt_ovf_i && !rst_pin_i)
        |=> (stk_we_o && $stable(stk_addr_o) && $stable(stk_data_o))); // R6

    AST_MASK_LEADS_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch_start_o |-> $past(mask_set_o, 2)); // R8

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fetch_start_o |=> !fetch_start_o); // R9

    AST_WDT_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        wdt_ovf_i |=> (!stk_we_o && !fetch_start_o)); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .CCR_W    (CCR_W),
    .MASK_BIT (MASK_BIT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rst_pin_i     (rst_pin_i),
    .wdt_ovf_i     (wdt_ovf_i),
    .insn_done_i   (insn_done_i),
    .ccr_write_i   (ccr_write_i),
    .ccr_i         (ccr_i),
    .stk_rdy_i     (stk_rdy_i),
    .irq_ack_o     (irq_ack_o),
    .trap_ack_o    (trap_ack_o),
    .stk_we_o      (stk_we_o),
    .stk_addr_o    (stk_addr_o),
    .stk_data_o    (stk_data_o),
    .mask_set_o    (mask_set_o),
    .fetch_start_o (fetch_start_o)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_pin = 1'b0, wdt = 1'b0;
    logic        irq_req = 1'b0, trap_req = 1'b0;
    logic [7:0]  irq_vec = '0, trap_vec = '0;
    logic        insn_done = 1'b0, ccr_wr = 1'b0;
    logic [31:0] pc = '0, sp = '0;
    logic [7:0]  ccr = '0;
    logic        stk_rdy = 1'b1;
    logic        irq_ack, trap_ack, stk_we, mask_set, fetch_start;
    logic [31:0] stk_addr, vec_addr;
    logic [15:0] stk_data;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int wr_cnt, mask_cnt, fs_cnt, ia_cnt, ta_cnt, mask_cyc, fs_cyc;
    logic [31:0] wr_addr [4];
    logic [15:0] wr_data [4];
    logic [31:0] fs_addr;

    exc_entry_seq u0 (
        .clk(clk), .rst(rst), .rst_pin_i(rst_pin), .wdt_ovf_i(wdt),
        .irq_req_i(irq_req), .irq_vec_i(irq_vec),
        .trap_req_i(trap_req), .trap_vec_i(trap_vec),
        .insn_done_i(insn_done), .ccr_write_i(ccr_wr),
        .pc_i(pc), .ccr_i(ccr), .sp_i(sp), .stk_rdy_i(stk_rdy),
        .irq_ack_o(irq_ack), .trap_ack_o(trap_ack),
        .stk_we_o(stk_we), .stk_addr_o(stk_addr), .stk_data_o(stk_data),
        .mask_set_o(mask_set), .vec_addr_o(vec_addr), .fetch_start_o(fetch_start)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #3;
        stk_rdy = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : 1'($urandom % 2);
    end

    always @(negedge clk) if (!rst) begin
        if (stk_we && stk_rdy) begin
            if (wr_cnt < 4) begin
                wr_addr[wr_cnt] = stk_addr;
                wr_data[wr_cnt] = stk_data;
            end
            wr_cnt++;
        end
        if (mask_set) begin mask_cnt++; mask_cyc = cyc; end
        if (fetch_start) begin fs_cnt++; fs_cyc = cyc; fs_addr = vec_addr; end
        if (irq_ack) ia_cnt++;
        if (trap_ack) ta_cnt++;
    end

    function automatic logic [31:0] exp_vaddr(logic [7:0] v);
        return {22'd0, v, 2'b00};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #2; endtask

    task automatic clear_mon();
        wr_cnt = 0; mask_cnt = 0; fs_cnt = 0; ia_cnt = 0; ta_cnt = 0;
        mask_cyc = 0; fs_cyc = 0; fs_addr = '0;
    endtask

    task automatic boundary(output int t0);
        t0 = cyc;
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        ccr_wr = 1'b0;
    endtask

    task automatic wait_fs();
        for (int i = 0; i < 400 && fs_cnt == 0; i++) tick();
        repeat (2) tick();
    endtask

    task automatic warm();
        int t;
        clear_mon();
        boundary(t);
        repeat (3) tick();
    endtask

    // checks a full interrupt or trap entry
    task automatic chk_entry(string rq, bit is_irq, logic [7:0] v, logic [31:0] p,
                             logic [31:0] s, logic [7:0] c, int t0, bit timed);
        check(rq, "irq acks", ia_cnt, is_irq ? 1 : 0);
        check(rq, "trap acks", ta_cnt, is_irq ? 0 : 1);
        check("R6", "write count", wr_cnt, 3);
        check("R6", "addr hi", wr_addr[0], s - 2);
        check("R6", "data hi", wr_data[0], p[31:16]);
        check("R6", "addr lo", wr_addr[1], s - 4);
        check("R6", "data lo", wr_data[1], p[15:0]);
        check("R6", "addr ccr", wr_addr[2], s - 6);
        check("R6", "data ccr", wr_data[2], {8'h00, c});
        check("R8", "mask pulses", mask_cnt, 1);
        check("R8", "mask lead", fs_cyc - mask_cyc, 2);
        check("R9", "fetch pulses", fs_cnt, 1);
        check("R9", "vector", fs_addr, exp_vaddr(v));
        if (timed) check("R11", "entry latency", fs_cyc - t0, 6);
    endtask

    task automatic chk_reset_entry(string rq);
        check("R7", "reset writes", wr_cnt, 0);
        check("R7", "reset vector", fs_addr, 32'h0);
        check(rq, "reset fetches", fs_cnt, 1);
        check("R8", "reset mask pulses", mask_cnt, 1);
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t0;
        void'($urandom(32'h5eed_1234));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R9", "reset state fetch", fetch_start, 0);
        check("R6", "reset state we", stk_we, 0);
        check("R8", "reset state mask", mask_set, 0);
        check("R3", "reset state ack", irq_ack, 0);

        // pin rising edge, then held high
        clear_mon(); t0 = cyc; rst_pin = 1'b1;
        wait_fs();
        chk_reset_entry("R2");
        check("R11", "reset latency", fs_cyc - t0, 3);
        repeat (10) tick();
        check("R2", "held pin no retrigger", fs_cnt, 1);
        rst_pin = 1'b0; tick();

        // first boundary after reset entry blocks the interrupt
        ccr = 8'h00; irq_req = 1'b1; irq_vec = 8'h21; pc = 32'h1234_5678; sp = 32'h0000_8000;
        clear_mon(); boundary(t0); repeat (10) tick();
        check("R4", "post-reset irq ack", ia_cnt, 0);
        check("R4", "post-reset fetch", fs_cnt, 0);
        clear_mon(); boundary(t0); wait_fs();
        chk_entry("R3", 1, 8'h21, 32'h1234_5678, 32'h0000_8000, 8'h00, t0, 1);
        irq_req = 1'b0;

        // masked interrupt ignored, trap under mask taken
        ccr = 8'h80; irq_req = 1'b1;
        clear_mon(); boundary(t0); repeat (10) tick();
        check("R3", "masked irq ack", ia_cnt, 0);
        check("R3", "masked irq fetch", fs_cnt, 0);
        trap_req = 1'b1; trap_vec = 8'h0C; ccr = 8'h85; sp = 32'h0000_4000;
        clear_mon(); boundary(t0); wait_fs();
        chk_entry("R5", 0, 8'h0C, 32'h1234_5678, 32'h0000_4000, 8'h85, t0, 1);
        trap_req = 1'b0; irq_req = 1'b0;

        // CCR-writing boundary: trap wins, irq waits
        ccr = 8'h00; irq_req = 1'b1; irq_vec = 8'h40; trap_req = 1'b1; trap_vec = 8'h08;
        clear_mon(); ccr_wr = 1'b1; boundary(t0); wait_fs();
        check("R4", "ccr write irq ack", ia_cnt, 0);
        check("R5", "ccr write trap vector", fs_addr, exp_vaddr(8'h08));
        trap_req = 1'b0;
        clear_mon(); boundary(t0); wait_fs();
        check("R1", "pending irq later", ia_cnt, 1);
        check("R1", "pending irq vector", fs_addr, exp_vaddr(8'h40));
        irq_req = 1'b0;

        // irq over trap, trap kept pending
        irq_req = 1'b1; irq_vec = 8'h11; trap_req = 1'b1; trap_vec = 8'h22;
        clear_mon(); boundary(t0); wait_fs();
        check("R1", "both: irq ack", ia_cnt, 1);
        check("R1", "both: trap ack", ta_cnt, 0);
        check("R1", "both: vector", fs_addr, exp_vaddr(8'h11));
        irq_req = 1'b0;
        clear_mon(); boundary(t0); wait_fs();
        check("R1", "pending trap later", ta_cnt, 1);
        check("R1", "pending trap vector", fs_addr, exp_vaddr(8'h22));
        trap_req = 1'b0;

        // watchdog strobe while idle
        clear_mon(); wdt = 1'b1; tick(); wdt = 1'b0; wait_fs();
        chk_reset_entry("R2");
        warm();

        // reset against a boundary with interrupt pending
        irq_req = 1'b1; irq_vec = 8'h33;
        clear_mon(); wdt = 1'b1; boundary(t0); wdt = 1'b0; wait_fs();
        check("R1", "reset beats irq ack", ia_cnt, 0);
        chk_reset_entry("R1");
        warm();
        irq_req = 1'b0;

        // reset aborts a stalled push
        rdy_mode = 2; irq_req = 1'b1; irq_vec = 8'h05;
        clear_mon(); boundary(t0); irq_req = 1'b0; repeat (5) tick();
        rst_pin = 1'b1; wait_fs(); rdy_mode = 0; repeat (4) tick();
        check("R10", "abort writes", wr_cnt, 0);
        check("R10", "abort fetches", fs_cnt, 1);
        check("R10", "abort vector", fs_addr, 32'h0);
        rst_pin = 1'b0; tick(); warm();

        // reset lands in the vector step
        irq_req = 1'b1; irq_vec = 8'h44;
        clear_mon(); boundary(t0); irq_req = 1'b0;
        repeat (4) tick();
        wdt = 1'b1; tick(); wdt = 1'b0; wait_fs();
        check("R10", "late abort fetches", fs_cnt, 1);
        check("R10", "late abort vector", fs_addr, 32'h0);
        check("R10", "late abort masks", mask_cnt, 2);
        warm();

        // random rounds
        for (int it = 0; it < 60; it++) begin
            logic ir, tr, cw, expi, expt;
            ir = 1'($urandom); tr = 1'($urandom); cw = 1'($urandom % 4 == 0);
            ccr = 8'($urandom); pc = $urandom; sp = {$urandom, 1'b0} >> 0;
            sp[0] = 1'b0;
            irq_vec = 8'($urandom); trap_vec = 8'($urandom);
            rdy_mode = int'($urandom % 2);
            irq_req = ir; trap_req = tr;
            expi = ir && !ccr[7] && !cw;
            expt = !expi && tr;
            clear_mon(); ccr_wr = cw; boundary(t0);
            irq_req = 1'b0; trap_req = 1'b0;
            if (expi || expt) begin
                wait_fs();
                chk_entry(expi ? "R3" : "R5", expi, expi ? irq_vec : trap_vec,
                          pc, sp, ccr, t0, rdy_mode == 0);
            end else begin
                repeat (10) tick();
                check("R4", "random no entry", fs_cnt, 0);
            end
        end
        rdy_mode = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule